// File: doc/BRIEF.md
# Half-Word Store Execution Unit

This unit executes the four half-word store instructions of a 64-bit big-endian integer core: displacement, displacement with update, indexed, and indexed with update. Each cycle it can take one 32-bit instruction word under a valid strobe. With the word come the 64-bit values of the source register, the base register and the index register, which an external register file reads. The unit forms the effective address, stores the low half-word as two byte writes to memory, high byte first, and hands the truncated address back to the register file for the update forms.

Each store also sends a one-cycle reservation-kill pulse with its address, so that an outside load-reserve monitor can drop a matching reservation. An update-form word whose base field is zero raises an illegal pulse and does nothing else. A word that is not one of the four stores raises a not-handled pulse and has no effect.

Top module: `hw_store_unit`

## Requirements
- R1: Bits are numbered from the LSB. Primary opcode = word[31:26]. Value 44 is the displacement store and 45 is the displacement store with update. Opcode 31 with word[10:1] = 407 is the indexed store, and with word[10:1] = 439 it is the indexed store with update. Source field = word[25:21], base field = word[20:16], index field = word[15:11], displacement = word[15:0].
- R2: In the displacement forms, EA = base + the displacement sign-extended to 64 bits, taken modulo 2^64.
- R3: In the indexed forms, EA = base + the full 64-bit index value, taken modulo 2^64.
- R4: In the non-update forms, a base field of zero makes the base a literal zero, whatever value the base register holds.
- R5: An update form raises wb_valid, with wb_reg equal to the base field and wb_data equal to the 32-bit truncated EA zero-extended to 64 bits. It does so in exactly the cycle in which done is high. Non-update forms never raise wb_valid.
- R6: An update form with a base field of zero gives a one-cycle illegal pulse. It makes no memory write, no write-back, no reservation pulse and no done.
- R7: Only source bits [15:0] are stored. The first byte write goes to EA and carries bits [15:8]. The second goes to EA+1 and carries bits [7:0]. The upper 48 source bits have no effect.
- R8: There is no alignment check. An odd EA stores normally, and EA+1 wraps within 32 bits, so 0xFFFFFFFF is followed by 0x00000000.
- R9: Every executed store gives resv_kill for exactly one cycle, with resv_addr equal to the truncated EA. This happens in the cycle in which the first byte request is presented.
- R10: A word that matches none of the four encodings gives a one-cycle unhandled pulse and no other output activity. Bit 0 (the record bit) of the indexed forms has no effect.
- R11: mem_valid keeps mem_addr and mem_byte stable until mem_ready is seen. done follows in the cycle after the second byte is accepted. in_ready is high only when the unit is idle, and after reset the unit is idle with all requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid |
| in_word | input | 32 | Instruction word |
| src_val | input | 64 | Value of the source register |
| base_val | input | 64 | Value of the register named by the base field |
| idx_val | input | 64 | Value of the register named by the index field |
| in_ready | output | 1 | Unit idle, word accepted this cycle |
| mem_valid | output | 1 | Byte write request |
| mem_addr | output | 32 | Byte address |
| mem_byte | output | 8 | Byte data |
| mem_ready | input | 1 | Memory accepts the byte this cycle |
| done | output | 1 | Store finished (one cycle) |
| wb_valid | output | 1 | Base-register write-back for update forms |
| wb_reg | output | 5 | Register index to write back |
| wb_data | output | 64 | Write-back value |
| resv_kill | output | 1 | Reservation invalidate strobe |
| resv_addr | output | 32 | Address carried with resv_kill |
| illegal | output | 1 | Invalid update form (one cycle) |
| unhandled | output | 1 | Word is not a half-word store (one cycle) |

## Verification
The assertions assume that the register values arrive in the same cycle as an accepted word. They also assume that mem_ready comes only from the memory side and that the bench does not inspect it before a request exists. The stimulus offers a word only while in_ready is high and holds it for that single cycle. It gives mem_ready in fixed stall patterns, so a request is sometimes held for several cycles. All inputs change on the falling edge, so every handshake is decided cleanly on the rising edge.

// File: rtl/hw_store_unit.sv
module hw_store_unit #(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_word,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] idx_val,
  output logic            in_ready,
  output logic            mem_valid,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_byte,
  input  logic            mem_ready,
  output logic            done,
  output logic            wb_valid,
  output logic [4:0]      wb_reg,
  output logic [XLEN-1:0] wb_data,
  output logic            resv_kill,
  output logic [AW-1:0]   resv_addr,
  output logic            illegal,
  output logic            unhandled
);
  localparam int PAD = XLEN - AW;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_FIN} st_t;
  st_t state;

  logic [AW-1:0] ea_q;
  logic [15:0]   half_q;
  logic          upd_q, resv_q, ill_q, unh_q;
  logic [4:0]    rfld_q;

  wire [5:0] opcd   = in_word[31:26];
  wire [4:0] afld   = in_word[20:16];
  wire [9:0] xo     = in_word[10:1];
  wire       d_form = (opcd == 6'd44) || (opcd == 6'd45);
  wire       x_form = (opcd == 6'd31) && ((xo == 10'd407) || (xo == 10'd439));
  wire       upd    = (opcd == 6'd45) || (x_form && xo == 10'd439);
  wire       take   = in_valid && (state == S_IDLE);

  wire [XLEN-1:0] base   = (afld == 5'd0 && !upd) ? '0 : base_val;
  wire [XLEN-1:0] offs   = d_form ? {{(XLEN-16){in_word[15]}}, in_word[15:0]} : idx_val;
  wire [XLEN-1:0] ea_all = base + offs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ea_q   <= '0;
      half_q <= '0;
      upd_q  <= 1'b0;
      rfld_q <= '0;
      resv_q <= 1'b0;
      ill_q  <= 1'b0;
      unh_q  <= 1'b0;
    end else begin
      resv_q <= 1'b0;
      ill_q  <= 1'b0;
      unh_q  <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          if (!(d_form || x_form)) unh_q <= 1'b1;
          else if (upd && afld == 5'd0) ill_q <= 1'b1;
          else begin
            state  <= S_HI;
            ea_q   <= ea_all[AW-1:0];
            half_q <= src_val[15:0];
            upd_q  <= upd;
            rfld_q <= afld;
            resv_q <= 1'b1;
          end
        end
        S_HI:  if (mem_ready) state <= S_LO;
        S_LO:  if (mem_ready) state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == S_IDLE);
  assign mem_valid = (state == S_HI) || (state == S_LO);
  assign mem_addr  = (state == S_LO) ? ea_q + AW'(1) : ea_q;
  assign mem_byte  = (state == S_LO) ? half_q[7:0] : half_q[15:8];
  assign done      = (state == S_FIN);
  assign wb_valid  = done && upd_q;
  assign wb_reg    = rfld_q;
  assign wb_data   = {{PAD{1'b0}}, ea_q};
  assign resv_kill = resv_q;
  assign resv_addr = ea_q;
  assign illegal   = ill_q;
  assign unhandled = unh_q;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_byte));
  p_next_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resv_kill && mem_ready |=> mem_valid && mem_addr == $past(mem_addr) + AW'(1));
  p_resv_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resv_kill |-> mem_valid && mem_addr == resv_addr);
  p_resv_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resv_kill |=> !resv_kill);
  p_wb_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done && wb_data[XLEN-1:AW] == '0);
  p_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal, unhandled}));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || unhandled) |-> !mem_valid && !resv_kill && !wb_valid);
endmodule

// File: tb/test_hw_store_unit.sv
module test_hw_store_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [63:0] src_val = '0, base_val = '0, idx_val = '0;
  logic        mem_ready = 1'b0;
  logic        in_ready, mem_valid, done, wb_valid, resv_kill, illegal, unhandled;
  logic [31:0] mem_addr, resv_addr;
  logic [7:0]  mem_byte;
  logic [4:0]  wb_reg;
  logic [63:0] wb_data;

  int n_vec = 0, n_bad = 0;

  int          wr_n, rv_n, wb_n, dn_n, il_n, un_n;
  logic [31:0] wr_a [4];
  logic [7:0]  wr_d [4];
  logic [31:0] rv_a;
  logic [4:0]  wb_r;
  logic [63:0] wb_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_store_unit i_hw_store_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .src_val(src_val), .base_val(base_val), .idx_val(idx_val),
    .in_ready(in_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_byte(mem_byte), .mem_ready(mem_ready), .done(done),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .resv_kill(resv_kill), .resv_addr(resv_addr),
    .illegal(illegal), .unhandled(unhandled));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dw(input int op, input int rs, input int ra, input logic [15:0] d);
    return {6'(op), 5'(rs), 5'(ra), d};
  endfunction

  function automatic logic [31:0] xw(input int rs, input int ra, input int rb, input int xo, input bit rc);
    return {6'd31, 5'(rs), 5'(ra), 5'(rb), 10'(xo), rc};
  endfunction

  task automatic run(input logic [31:0] w, input logic [63:0] s, input logic [63:0] b,
                     input logic [63:0] x, input int stall);
    wr_n = 0; rv_n = 0; wb_n = 0; dn_n = 0; il_n = 0; un_n = 0;
    @(negedge clk);
    in_valid = 1'b1; in_word = w; src_val = s; base_val = b; idx_val = x;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      mem_ready = (c % stall) == (stall - 1);
      #1;
      if (mem_valid && mem_ready && wr_n < 4) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_byte; wr_n++; end
      if (resv_kill) begin rv_n++; rv_a = resv_addr; end
      if (wb_valid)  begin wb_n++; wb_r = wb_reg; wb_d = wb_data; end
      if (illegal)   il_n++;
      if (unhandled) un_n++;
      if (done)      dn_n++;
      if (done || illegal || unhandled) break;
      if (c == 59) chk(1'b0, "R11 timeout", 0, 1);
    end
    mem_ready = 1'b0;
  endtask

  task automatic expect_store(input string req, input logic [31:0] ea, input logic [15:0] h,
                              input bit upd, input int ra);
    chk(dn_n == 1, {req, " done"}, dn_n, 1);
    chk(wr_n == 2, {req, " R7 byte count"}, wr_n, 2);
    chk(wr_a[0] == ea && wr_d[0] == h[15:8], {req, " R7 first byte"}, {wr_a[0], wr_d[0]}, {ea, h[15:8]});
    chk(wr_a[1] == ea + 32'd1 && wr_d[1] == h[7:0], {req, " R7 second byte"}, {wr_a[1], wr_d[1]}, {ea + 32'd1, h[7:0]});
    chk(rv_n == 1 && rv_a == ea, {req, " R9 reservation"}, {rv_n[31:0], rv_a}, {32'd1, ea});
    if (upd) chk(wb_n == 1 && wb_r == 5'(ra) && wb_d == {32'd0, ea}, {req, " R5 write-back"}, wb_d, {32'd0, ea});
    else     chk(wb_n == 0, {req, " R5 no write-back"}, wb_n, 0);
  endtask

  task automatic expect_nothing(input string req, input bit ill);
    chk(wr_n == 0 && rv_n == 0 && wb_n == 0 && dn_n == 0, {req, " no side effects"},
        {wr_n[15:0], rv_n[15:0], wb_n[15:0], dn_n[15:0]}, 0);
    chk(ill ? (il_n == 1 && un_n == 0) : (un_n == 1 && il_n == 0), {req, " flag"}, {il_n, un_n}, {ill, !ill});
  endtask

  task automatic t_reset;
    #1;
    chk(in_ready && !mem_valid && !done && !resv_kill && !wb_valid && !illegal && !unhandled,
        "R11 reset state", {in_ready, mem_valid, done, resv_kill}, 4'b1000);
  endtask

  task automatic t_disp_plain;
    run(dw(44, 4, 5, 16'hFFFC), 64'hDEADBEEF_1234ABCD, 64'h1_0000_1000, 64'h0, 1);
    expect_store("R1 R2 disp", 32'h0000_0FFC, 16'hABCD, 0, 5);
  endtask

  task automatic t_disp_zero_base;
    run(dw(44, 2, 0, 16'h7FFE), 64'hFFFF_FFFF_FFFF_5A3C, 64'h5555, 64'h0, 2);
    expect_store("R4 disp base zero", 32'h0000_7FFE, 16'h5A3C, 0, 0);
  endtask

  task automatic t_disp_update;
    run(dw(45, 1, 7, 16'h0010), 64'h0000_0000_0000_BEEF, 64'hFFFF_FFFF_8000_0000, 64'h0, 3);
    expect_store("R5 R11 disp update", 32'h8000_0010, 16'hBEEF, 1, 7);
  endtask

  task automatic t_idx_plain;
    run(xw(6, 3, 8, 407, 0), 64'h1111_2222_3333_0102, 64'h2000, 64'h1_0000_0001, 1);
    expect_store("R3 R8 indexed odd", 32'h0000_2001, 16'h0102, 0, 3);
  endtask

  task automatic t_idx_zero_base;
    run(xw(6, 0, 8, 407, 0), 64'h0000_0000_0000_F00D, 64'hAAAA_AAAA, 64'h123, 2);
    expect_store("R4 indexed base zero", 32'h0000_0123, 16'hF00D, 0, 0);
  endtask

  task automatic t_idx_update_wrap;
    run(xw(6, 9, 8, 439, 1), 64'h0000_0000_0000_7788, 64'h0000_0000_FFFF_FFFF, 64'h0, 4);
    expect_store("R8 R10 indexed update wrap", 32'hFFFF_FFFF, 16'h7788, 1, 9);
  endtask

  task automatic t_update_zero;
    run(dw(45, 3, 0, 16'h0004), 64'h1234, 64'h4000, 64'h0, 1);
    expect_nothing("R6 disp update base zero", 1);
    run(xw(3, 0, 4, 439, 0), 64'h1234, 64'h4000, 64'h10, 1);
    expect_nothing("R6 indexed update base zero", 1);
  endtask

  task automatic t_unmatched;
    run(xw(3, 4, 5, 408, 0), 64'h1234, 64'h4000, 64'h10, 1);
    expect_nothing("R10 other extended opcode", 0);
    run(dw(46, 3, 4, 16'h0008), 64'h1234, 64'h4000, 64'h0, 1);
    expect_nothing("R10 other primary opcode", 0);
    run(32'h0, 64'h1234, 64'h4000, 64'h0, 1);
    expect_nothing("R10 zero word", 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disp_plain();
    t_disp_zero_base();
    t_disp_update();
    t_idx_plain();
    t_idx_zero_base();
    t_idx_update_wrap();
    t_update_zero();
    t_unmatched();
    t_disp_plain();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule